// File: doc/BRIEF.md
# Video Black-Level Clamp Direction Controller

This block watches digitized video samples during the black-level interval and decides, per channel, whether the clamp reference has to be raised or lowered. It handles three channels: one luma channel, and two colour-difference channels that share one converter and arrive on one time-multiplexed bus. A phase flag on that bus says which colour-difference channel the current code belongs to. While the clamp strobe is high, each channel compares its code with its own black target and produces a registered raise or lower pulse for an external charge pump. Luma aims at code 16. Both colour-difference channels aim at code 128, their zero point.

A dead band of plus or minus `dead_band` codes around each target suppresses correction, so the loop does not hunt around the target. While clamping, colour-difference data is flagged as invalid. A clamp interval shorter than the minimum length (60 cycles by default, which is 3 µs at 20 MHz) raises a one-cycle error pulse when the interval ends.

Top module: `clamp_ctrl`

## Requirements
- R1: While `clamp_req` is high, the luma pair is set one clock later. `corr_up[0]` is 1 when `luma_code + dead_band < 16`. `corr_dn[0]` is 1 when `luma_code > 16 + dead_band`.
- R2: While `clamp_req` is high, the colour-difference pairs use target 128 with the same rule. Bit 1 of `corr_up`/`corr_dn` is the U channel and bit 2 is the V channel.
- R3: A code within `dead_band` codes of its target, limits included, gives neither a raise nor a lower on that channel.
- R4: One clock after a cycle with `clamp_req` low, all six correction outputs are 0.
- R5: The colour-difference code is applied to U only when `chroma_sel` is 0, and to V only when it is 1. The channel that is not selected shows no correction one clock later.
- R6: `chroma_invalid` equals `clamp_req` delayed by one clock.
- R7: When `clamp_req` falls after being high for 1 to MIN_WIN-1 consecutive cycles, `short_err` is 1 for exactly one clock, one clock after the first low cycle. A run of MIN_WIN or more cycles gives no pulse.
- R8: A synchronous active-high `rst` clears all correction outputs, `chroma_invalid` and `short_err`, and restarts the interval-length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| clamp_req | input | 1 | Clamp interval strobe, active high |
| luma_code | input | 8 | Raw luma sample code |
| chroma_code | input | 8 | Multiplexed colour-difference sample code |
| chroma_sel | input | 1 | Phase of the chroma bus: 0 = U, 1 = V |
| dead_band | input | 4 | Half-width of the no-correction band, in codes |
| corr_up | output | 3 | Raise pulses: bit 0 luma, bit 1 U, bit 2 V |
| corr_dn | output | 3 | Lower pulses: bit 0 luma, bit 1 U, bit 2 V |
| chroma_invalid | output | 1 | Colour-difference data invalid while clamping |
| short_err | output | 1 | Pulse: the clamp interval ended too early |

## Verification
The hardest cases to reach are the limits of the interval-length check. The stimulus holds the strobe for exactly MIN_WIN-1 and exactly MIN_WIN cycles and looks at the single cycle after the fall. It also resets the block in the middle of a long interval and then ends the interval while the count since reset is still short. The error pulse then only appears if the reset really cleared the count. The dead-band limits are hit with codes one step inside and one step outside the band on both sides of each target.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int NCH   = 3;
  localparam int CH_Y  = 0;
  localparam int CH_U  = 1;
  localparam int CH_V  = 2;
endpackage

// File: rtl/clamp_dir.sv
module clamp_dir #(
  parameter int W    = 8,
  parameter int DB_W = 4,
  parameter int TGT  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [W-1:0]    code,
  input  logic [DB_W-1:0] db,
  output logic            up,
  output logic            dn
);
  localparam int XW = W + 2;
  localparam logic [XW-1:0] T_X = XW'(TGT);

  logic [XW-1:0] code_x, db_x;
  logic below, above;

  always_comb begin
    code_x = XW'(code);
    db_x   = XW'(db);
    below  = (code_x + db_x) < T_X;
    above  = code_x > (T_X + db_x);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= below;
      dn <= above;
    end
  end
endmodule

// File: rtl/clamp_window.sv
module clamp_window #(
  parameter int MIN_WIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic clamp_req,
  output logic chroma_invalid,
  output logic short_err
);
  localparam int CW = $clog2(MIN_WIN + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_WIN);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len        <= '0;
      chroma_invalid <= 1'b0;
      short_err      <= 1'b0;
    end else begin
      chroma_invalid <= clamp_req;
      if (clamp_req) begin
        short_err <= 1'b0;
        if (run_len != LIM) run_len <= run_len + 1'b1;
      end else begin
        short_err <= (run_len != '0) && (run_len < LIM);
        run_len   <= '0;
      end
    end
  end
endmodule

// File: rtl/clamp_ctrl.sv
module clamp_ctrl #(
  parameter int W        = 8,
  parameter int DB_W     = 4,
  parameter int MIN_WIN  = 60,
  parameter int Y_TGT    = 16,
  parameter int C_TGT    = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clamp_req,
  input  logic [W-1:0]    luma_code,
  input  logic [W-1:0]    chroma_code,
  input  logic            chroma_sel,
  input  logic [DB_W-1:0] dead_band,
  output logic [2:0]      corr_up,
  output logic [2:0]      corr_dn,
  output logic            chroma_invalid,
  output logic            short_err
);
  import clamp_pkg::*;

  logic [NCH-1:0] ch_en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == CH_Y) begin : g_luma
      assign ch_en[g] = clamp_req;
      clamp_dir #(.W(W), .DB_W(DB_W), .TGT(Y_TGT)) u_dir (
        .clk(clk), .rst(rst), .en(ch_en[g]), .code(luma_code), .db(dead_band),
        .up(corr_up[g]), .dn(corr_dn[g]));
    end else begin : g_chroma
      assign ch_en[g] = clamp_req & (chroma_sel == (g == CH_V));
      clamp_dir #(.W(W), .DB_W(DB_W), .TGT(C_TGT)) u_dir (
        .clk(clk), .rst(rst), .en(ch_en[g]), .code(chroma_code), .db(dead_band),
        .up(corr_up[g]), .dn(corr_dn[g]));
    end
  end

  clamp_window #(.MIN_WIN(MIN_WIN)) u_win (
    .clk(clk), .rst(rst), .clamp_req(clamp_req),
    .chroma_invalid(chroma_invalid), .short_err(short_err));
endmodule

// File: rtl/clamp_ctrl_chk.sv
module clamp_ctrl_chk #(
  parameter int W     = 8,
  parameter int Y_TGT = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         clamp_req,
  input logic [W-1:0] luma_code,
  input logic         chroma_sel,
  input logic [2:0]   corr_up,
  input logic [2:0]   corr_dn,
  input logic         chroma_invalid,
  input logic         short_err
);
  assert_no_conflict_R1: assert property (@(posedge clk) disable iff (rst)
    (corr_up & corr_dn) == 3'b000);
  assert_luma_on_target_R3: assert property (@(posedge clk) disable iff (rst)
    (clamp_req && luma_code == W'(Y_TGT)) |=> (!corr_up[0] && !corr_dn[0]));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !clamp_req |=> (corr_up == 3'b000 && corr_dn == 3'b000));
  assert_v_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (clamp_req && !chroma_sel) |=> (!corr_up[2] && !corr_dn[2]));
  assert_u_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (clamp_req && chroma_sel) |=> (!corr_up[1] && !corr_dn[1]));
  assert_invalid_set_R6: assert property (@(posedge clk) disable iff (rst)
    clamp_req |=> chroma_invalid);
  assert_invalid_clr_R6: assert property (@(posedge clk) disable iff (rst)
    !clamp_req |=> !chroma_invalid);
  assert_err_after_fall_R7: assert property (@(posedge clk) disable iff (rst)
    short_err |-> !$past(clamp_req));
  assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
    short_err |=> !short_err);
endmodule

bind clamp_ctrl clamp_ctrl_chk #(.W(W), .Y_TGT(Y_TGT)) u_chk (
  .clk(clk), .rst(rst), .clamp_req(clamp_req), .luma_code(luma_code),
  .chroma_sel(chroma_sel), .corr_up(corr_up), .corr_dn(corr_dn),
  .chroma_invalid(chroma_invalid), .short_err(short_err));

// File: tb/tb_clamp_ctrl.sv
module tb_clamp_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clamp_req = 1'b0;
  logic [7:0] luma_code = '0;
  logic [7:0] chroma_code = '0;
  logic       chroma_sel = 1'b0;
  logic [3:0] dead_band = '0;
  logic [2:0] corr_up, corr_dn;
  logic       chroma_invalid, short_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  clamp_ctrl dut (
    .clk(clk), .rst(rst), .clamp_req(clamp_req), .luma_code(luma_code),
    .chroma_code(chroma_code), .chroma_sel(chroma_sel), .dead_band(dead_band),
    .corr_up(corr_up), .corr_dn(corr_dn), .chroma_invalid(chroma_invalid),
    .short_err(short_err));

  // {clamp, sel, luma, chroma, db, exp_up[V,U,Y], exp_dn[V,U,Y]}
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd10,  8'd100, 4'd0,  3'b011, 3'b000},  // R1 R2 R5
    {1'b1, 1'b1, 8'd200, 8'd200, 4'd0,  3'b000, 3'b101},  // R1 R2 R5
    {1'b1, 1'b0, 8'd16,  8'd128, 4'd0,  3'b000, 3'b000},  // R3
    {1'b1, 1'b1, 8'd17,  8'd127, 4'd0,  3'b100, 3'b001},  // R1 R2
    {1'b1, 1'b0, 8'd18,  8'd130, 4'd2,  3'b000, 3'b000},  // R3 upper edge
    {1'b1, 1'b0, 8'd19,  8'd131, 4'd2,  3'b000, 3'b011},  // R3 just outside
    {1'b1, 1'b1, 8'd13,  8'd125, 4'd2,  3'b101, 3'b000},  // R3 just outside
    {1'b1, 1'b1, 8'd14,  8'd126, 4'd2,  3'b000, 3'b000},  // R3 lower edge
    {1'b1, 1'b0, 8'd0,   8'd0,   4'd15, 3'b011, 3'b000},  // R1 wide band
    {1'b1, 1'b0, 8'd1,   8'd255, 4'd15, 3'b000, 3'b010},  // R3 R2
    {1'b0, 1'b0, 8'd0,   8'd0,   4'd0,  3'b000, 3'b000},  // R4
    {1'b0, 1'b1, 8'd255, 8'd255, 4'd0,  3'b000, 3'b000},  // R4
    {1'b1, 1'b1, 8'd255, 8'd0,   4'd0,  3'b100, 3'b001}   // R1 R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_window(input int len, input logic exp_err, input string req);
    clamp_req = 1'b1;
    for (int i = 0; i < len; i++) tick();
    clamp_req = 1'b0;
    tick();
    chk(req, short_err, exp_err);
    tick();
    chk(req, short_err, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    chk("R8 up", corr_up, 3'b000);
    chk("R8 dn", corr_dn, 3'b000);
    chk("R8 inv", chroma_invalid, 1'b0);
    chk("R8 err", short_err, 1'b0);
    rst = 1'b0;
    tick();

    for (int v = 0; v < NV; v++) begin
      clamp_req   = VEC[v][27];
      chroma_sel  = VEC[v][26];
      luma_code   = VEC[v][25:18];
      chroma_code = VEC[v][17:10];
      dead_band   = VEC[v][9:6];
      tick();
      chk($sformatf("R1/R2/R3/R4/R5 up v%0d", v), corr_up, VEC[v][5:3]);
      chk($sformatf("R1/R2/R3/R4/R5 dn v%0d", v), corr_dn, VEC[v][2:0]);
      chk($sformatf("R6 inv v%0d", v), chroma_invalid, VEC[v][27]);
    end

    clamp_req = 1'b0;
    dead_band = 4'd0;
    tick();
    tick();
    run_window(59, 1'b1, "R7 short by one");
    run_window(60, 1'b0, "R7 exact minimum");
    run_window(1,  1'b1, "R7 single cycle");
    run_window(90, 1'b0, "R7 long");

    // R8: reset inside a long window clears the count and outputs
    luma_code = 8'd0;
    clamp_req = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    chk("R1 luma raise in window", corr_up[0], 1'b1);
    rst = 1'b1;
    tick();
    chk("R8 up in reset", corr_up, 3'b000);
    chk("R8 inv in reset", chroma_invalid, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) tick();
    clamp_req = 1'b0;
    tick();
    chk("R8 count cleared", short_err, 1'b1);
    chk("R4 quiet after window", corr_up | corr_dn, 3'b000);
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule